// File: doc/BRIEF.md
# SECDED Protected RAM Controller

This block holds an on-chip RAM of 128-bit lines and keeps 9 check bits beside each line. It serves 32-bit word and 128-bit line accesses through a request/ready and response-valid handshake. Only one access is in flight at a time. In an ECC access a write stores freshly computed check bits. A read checks the stored line, corrects any single flipped bit and reports a double flip as uncorrectable. A 32-bit write into a protected line is done as read, merge, recompute and write.

Configuration inputs set the behaviour. A 3-bit mode picks non-ECC data, non-ECC code, full ECC, or ECC limited to a window of lines. Other inputs enable write-back of corrected lines, enable flagging of uncorrectable errors in the response, and enable a one-cycle-shorter read for non-ECC accesses. Event outputs report each corrected error, each uncorrectable error and each address error as a single-cycle pulse. Each pulse carries the word address of the access and, for a corrected error, the position of the bit that was wrong.

Non-ECC accesses never touch the check bits. A line changed in a non-ECC mode therefore shows errors when it is later read with ECC. This is how the bench injects faults.

Top module: `ecc_ram_ctrl`

## Requirements
- R1: A 128-bit write at a word address with bits [1:0] = 0, in an ECC mode, stores the data and all 9 check bits in one RAM write. It acknowledges in the cycle after the accept edge. A later ECC read returns the data with no event.
- R2: An ECC read of a line with one flipped data bit returns corrected data. It pulses sec_o with err_addr_o = the word address of the access and sec_bit_o = the flipped bit index, where data bits are 0 to 127, Hamming check bits are 128 to 135 and the overall parity bit is 136. sec_o and ded_o are never high together.
- R3: An ECC read of a line with two flipped bits pulses ded_o and returns the stored data unchanged. rerr_o is set with the response only when err_resp_en_i = 1.
- R4: With auto_corr_i = 1, a corrected line is written back in the check cycle, and the next ECC read of that line is clean. With auto_corr_i = 0 the RAM is left as it was, and the error is reported again.
- R5: A 32-bit write in an ECC mode reads the line, replaces word addr_i[1:0], recomputes the check bits and writes the line back. It acknowledges in the second cycle after the accept edge. The other three words are kept.
- R6: If the read step of R5 finds a double error, ded_o pulses and rerr_o follows err_resp_en_i. The merged line is still written with new check bits, so later ECC reads of it are clean.
- R7: Modes 3'b000 and 3'b001 are non-ECC. Reads return raw data with no events. Writes change data only and never the check bits. A 32-bit write is one RAM write, acknowledged in the cycle after the accept edge.
- R8: Mode codes with bit 2 set behave exactly like 3'b000.
- R9: With fast_nonecc_i = 1, a non-ECC read responds in the cycle after the accept edge. Otherwise a read responds in the second cycle after it. ECC reads are never shortened.
- R10: Mode 3'b011 applies ECC only when the line index addr_i[ADDR_W-1:2] lies in [win_lo_i, win_hi_i], both bounds inclusive. Outside that window the access is non-ECC.
- R11: A line index >= LINES, or a 128-bit access with addr_i[1:0] != 0, is an address error. It makes no RAM access. addr_err_o pulses with err_addr_o = addr_i, and the response comes in the cycle after the accept edge with zero data and rerr_o = err_resp_en_i.
- R12: During reset ready_o = 1, and rvalid_o, sec_o, ded_o and addr_err_o are 0.
- R13: In the cycle after accepting a two-cycle access, ready_o and rvalid_o are 0. A 32-bit read returns its word in rdata_o[31:0] with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Access mode: 000 non-ECC data, 001 non-ECC code, 010 full ECC, 011 windowed ECC, 1xx as 000 |
| auto_corr_i | input | 1 | Write corrected lines back |
| err_resp_en_i | input | 1 | Flag uncorrectable and address errors on rerr_o |
| fast_nonecc_i | input | 1 | One-cycle read for non-ECC accesses |
| win_lo_i | input | ADDR_W-2 | First line of the ECC window |
| win_hi_i | input | ADDR_W-2 | Last line of the ECC window |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 128-bit access, 0 = 32-bit |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 128 | Write data (32-bit writes use bits 31:0) |
| ready_o | output | 1 | Request accepted on the edge when req_i is also high |
| rvalid_o | output | 1 | Response valid, one cycle per access |
| rdata_o | output | 128 | Read data |
| rerr_o | output | 1 | Error flag with the response |
| sec_o | output | 1 | Corrected-error pulse |
| ded_o | output | 1 | Uncorrectable-error pulse |
| addr_err_o | output | 1 | Address-error pulse |
| err_addr_o | output | ADDR_W | Word address of the last reported event |
| sec_bit_o | output | 8 | Bit position of the last corrected error |

## Verification
Results fall due at two points. Address errors, line writes, non-ECC word writes and fast non-ECC reads respond in the cycle after the accept edge. ECC reads, read-merge-write cycles and non-fast non-ECC reads respond one cycle later, and the error event pulses share that same response cycle. The bench drives on falling edges and counts falling edges from the accept edge until rvalid_o rises. It checks that count against the latency the requirement states, and it samples data, rerr_o and the event outputs in that same response cycle. Faults are placed by rewriting data in a non-ECC mode, which leaves the old check bits in place, and the corrected, raw or rewritten content is then read back through the ports.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;
  localparam int DW  = 128;
  localparam int HW  = 8;
  localparam int CW  = HW + 1;
  localparam int NWD = DW / 32;

  typedef enum logic [2:0] {
    MODE_DATA  = 3'b000,
    MODE_CODE  = 3'b001,
    MODE_FULL  = 3'b010,
    MODE_BLOCK = 3'b011
  } mode_e;

  // codeword position of data bit k, skipping power-of-two slots
  function automatic logic [HW-1:0] ecc_pos(input int k);
    int p;
    p = k + 1;
    for (int i = 0; i < HW; i++)
      if ((1 << i) <= p) p++;
    return HW'(p);
  endfunction

  function automatic logic [HW-1:0] ecc_hamming(input logic [DW-1:0] d);
    logic [HW-1:0] h;
    h = '0;
    for (int k = 0; k < DW; k++)
      if (d[k]) h = h ^ ecc_pos(k);
    return h;
  endfunction
endpackage

// File: rtl/ecc_ram_enc.sv
module ecc_ram_enc
  import ecc_ram_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] chk_o
);
  logic [HW-1:0] h;

  always_comb begin
    h     = ecc_hamming(data_i);
    chk_o = {(^data_i) ^ (^h), h};
  end
endmodule

// File: rtl/ecc_ram_dec.sv
module ecc_ram_dec
  import ecc_ram_pkg::*;
(
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] chk_i,
  output logic [DW-1:0] data_o,
  output logic          sec_o,
  output logic          ded_o,
  output logic [7:0]    bit_o
);
  logic [HW-1:0] syn;
  logic          par;
  logic          hit;

  always_comb begin
    syn    = ecc_hamming(data_i) ^ chk_i[HW-1:0];
    par    = ^{data_i, chk_i};
    data_o = data_i;
    sec_o  = 1'b0;
    ded_o  = 1'b0;
    bit_o  = '0;
    hit    = 1'b0;
    if (par) begin
      if (syn == '0) begin
        sec_o = 1'b1;
        bit_o = 8'(DW + HW);
      end else begin
        for (int i = 0; i < HW; i++)
          if (syn == HW'(1 << i)) begin
            hit   = 1'b1;
            bit_o = 8'(DW + i);
          end
        for (int k = 0; k < DW; k++)
          if (syn == ecc_pos(k)) begin
            hit       = 1'b1;
            data_o[k] = ~data_i[k];
            bit_o     = 8'(k);
          end
        sec_o = hit;
        ded_o = !hit;  // syndrome points outside the codeword
      end
    end else if (syn != '0) begin
      ded_o = 1'b1;
    end
  end
endmodule

// File: rtl/ecc_ram_array.sv
module ecc_ram_array
  import ecc_ram_pkg::*;
#(
  parameter int LINES = 16,
  localparam int LAW  = $clog2(LINES)
) (
  input  logic           clk_i,
  input  logic [LAW-1:0] addr_i,
  input  logic           re_i,
  input  logic           we_i,
  input  logic [NWD-1:0] mask_i,
  input  logic           chk_we_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [CW-1:0]  wchk_i,
  output logic [DW-1:0]  rdata_o,
  output logic [CW-1:0]  rchk_o
);
  for (genvar w = 0; w < NWD; w++) begin : g_lane
    logic [31:0] mem [LINES];
    logic [31:0] q;
    always_ff @(posedge clk_i) begin
      if (we_i && mask_i[w]) mem[addr_i] <= wdata_i[w*32 +: 32];
      if (re_i) q <= mem[addr_i];
    end
    assign rdata_o[w*32 +: 32] = q;
  end

  logic [CW-1:0] cmem [LINES];
  always_ff @(posedge clk_i) begin
    if (we_i && chk_we_i) cmem[addr_i] <= wchk_i;
    if (re_i) rchk_o <= cmem[addr_i];
  end
endmodule

// File: rtl/ecc_ram_ctrl.sv
module ecc_ram_ctrl
  import ecc_ram_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              auto_corr_i,
  input  logic              err_resp_en_i,
  input  logic              fast_nonecc_i,
  input  logic [ADDR_W-3:0] win_lo_i,
  input  logic [ADDR_W-3:0] win_hi_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rerr_o,
  output logic              sec_o,
  output logic              ded_o,
  output logic              addr_err_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [7:0]        sec_bit_o
);
  localparam int LAW = $clog2(LINES);
  localparam int FW  = ADDR_W - 2;
  localparam logic [FW:0] LIMIT = (FW+1)'(LINES);

  typedef enum logic {ST_IDLE, ST_CHK} st_e;

  function automatic logic [DW-1:0] pick(input logic [DW-1:0] l, input logic w,
                                         input logic [1:0] idx);
    return w ? l : {{(DW-32){1'b0}}, l[idx*32 +: 32]};
  endfunction

  st_e               st_q;
  logic              we_q, wide_q, ecc_q, fast_q;
  logic [1:0]        word_q;
  logic [LAW-1:0]    line_q;
  logic [31:0]       wdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rvalid_q, rerr_q, sec_q, ded_q, aerr_q;
  logic [DW-1:0]     rdata_q;
  logic [ADDR_W-1:0] err_addr_q;
  logic [7:0]        sec_bit_q;

  // request decode
  logic [FW-1:0] line_f;
  logic [1:0]    word_f;
  mode_e         eff_mode;
  logic          in_win, ecc_f, bad_f, acc;

  always_comb begin
    line_f   = addr_i[ADDR_W-1:2];
    word_f   = addr_i[1:0];
    eff_mode = mode_i[2] ? MODE_DATA : mode_e'(mode_i);
    in_win   = (line_f >= win_lo_i) && (line_f <= win_hi_i);
    ecc_f    = (eff_mode == MODE_FULL) || ((eff_mode == MODE_BLOCK) && in_win);
    bad_f    = ({1'b0, line_f} >= LIMIT) || (wide_i && (word_f != 2'd0));
    acc      = req_i && ready_o;
  end

  // RAM and codec
  logic           ram_re, ram_we, ram_chk_we;
  logic [NWD-1:0] ram_mask;
  logic [LAW-1:0] ram_addr;
  logic [DW-1:0]  ram_wdata, ram_rdata, d_data, merged;
  logic [CW-1:0]  ram_wchk, ram_rchk;
  logic           d_sec, d_ded;
  logic [7:0]     d_bit;

  ecc_ram_array #(.LINES(LINES)) u_array (
    .clk_i   (clk_i),
    .addr_i  (ram_addr),
    .re_i    (ram_re),
    .we_i    (ram_we),
    .mask_i  (ram_mask),
    .chk_we_i(ram_chk_we),
    .wdata_i (ram_wdata),
    .wchk_i  (ram_wchk),
    .rdata_o (ram_rdata),
    .rchk_o  (ram_rchk)
  );

  ecc_ram_dec u_dec (
    .data_i(ram_rdata),
    .chk_i (ram_rchk),
    .data_o(d_data),
    .sec_o (d_sec),
    .ded_o (d_ded),
    .bit_o (d_bit)
  );

  // one encoder serves line writes, merges and write-backs
  ecc_ram_enc u_enc (
    .data_i(ram_wdata),
    .chk_o (ram_wchk)
  );

  always_comb begin
    merged = d_data;
    merged[word_q*32 +: 32] = wdata_q;
  end

  always_comb begin
    ram_re     = 1'b0;
    ram_we     = 1'b0;
    ram_chk_we = 1'b0;
    ram_mask   = '0;
    ram_addr   = line_f[LAW-1:0];
    ram_wdata  = merged;
    if (st_q == ST_IDLE) begin
      if (acc && !bad_f) begin
        if (!we_i) begin
          ram_re = 1'b1;
        end else if (wide_i) begin
          ram_we     = 1'b1;
          ram_mask   = '1;
          ram_chk_we = ecc_f;
          ram_wdata  = wdata_i;
        end else if (!ecc_f) begin
          ram_we           = 1'b1;
          ram_mask[word_f] = 1'b1;
          ram_wdata        = {NWD{wdata_i[31:0]}};
        end else begin
          ram_re = 1'b1;  // read step of read-merge-write
        end
      end
    end else begin
      ram_addr = line_q;
      if (we_q) begin
        ram_we     = 1'b1;
        ram_mask   = '1;
        ram_chk_we = 1'b1;
      end else if (ecc_q && auto_corr_i && d_sec) begin
        ram_we     = 1'b1;
        ram_mask   = '1;
        ram_chk_we = 1'b1;
        ram_wdata  = d_data;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      we_q       <= 1'b0;
      wide_q     <= 1'b0;
      ecc_q      <= 1'b0;
      fast_q     <= 1'b0;
      word_q     <= '0;
      line_q     <= '0;
      wdata_q    <= '0;
      addr_q     <= '0;
      rvalid_q   <= 1'b0;
      rerr_q     <= 1'b0;
      sec_q      <= 1'b0;
      ded_q      <= 1'b0;
      aerr_q     <= 1'b0;
      rdata_q    <= '0;
      err_addr_q <= '0;
      sec_bit_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      rerr_q   <= 1'b0;
      sec_q    <= 1'b0;
      ded_q    <= 1'b0;
      aerr_q   <= 1'b0;
      fast_q   <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (acc) begin
          we_q    <= we_i;
          wide_q  <= wide_i;
          ecc_q   <= ecc_f;
          word_q  <= word_f;
          line_q  <= line_f[LAW-1:0];
          wdata_q <= wdata_i[31:0];
          addr_q  <= addr_i;
          rdata_q <= '0;
          if (bad_f) begin
            rvalid_q   <= 1'b1;
            rerr_q     <= err_resp_en_i;
            aerr_q     <= 1'b1;
            err_addr_q <= addr_i;
          end else if (we_i && (wide_i || !ecc_f)) begin
            rvalid_q <= 1'b1;
          end else if (!we_i && !ecc_f && fast_nonecc_i) begin
            rvalid_q <= 1'b1;
            fast_q   <= 1'b1;
          end else begin
            st_q <= ST_CHK;
          end
        end
      end else begin
        st_q     <= ST_IDLE;
        rvalid_q <= 1'b1;
        if (ecc_q) begin
          rdata_q    <= we_q ? '0 : pick(d_data, wide_q, word_q);
          sec_q      <= d_sec;
          ded_q      <= d_ded;
          rerr_q     <= d_ded && err_resp_en_i;
          err_addr_q <= addr_q;
          if (d_sec) sec_bit_q <= d_bit;
        end else begin
          rdata_q <= pick(ram_rdata, wide_q, word_q);
        end
      end
    end
  end

  assign ready_o    = (st_q == ST_IDLE);
  assign rvalid_o   = rvalid_q;
  assign rdata_o    = fast_q ? pick(ram_rdata, wide_q, word_q) : rdata_q;
  assign rerr_o     = rerr_q;
  assign sec_o      = sec_q;
  assign ded_o      = ded_q;
  assign addr_err_o = aerr_q;
  assign err_addr_o = err_addr_q;
  assign sec_bit_o  = sec_bit_q;

  p_sec_ded_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_o && ded_o));

  p_rerr_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |-> (rvalid_o && (ded_o || addr_err_o)));

  p_single_port_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_re && ram_we));

  p_fast_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !we_i && !bad_f && !ecc_f && fast_nonecc_i) |=> (rvalid_o && !sec_o && !ded_o));

  p_addr_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && bad_f) |=> (addr_err_o && rvalid_o && (rerr_o == $past(err_resp_en_i))));

  p_busy_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !bad_f && ecc_f && !(we_i && wide_i)) |=> (!ready_o && !rvalid_o));
endmodule

// File: tb/ecc_ram_ctrl_tb.sv
module ecc_ram_ctrl_tb;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = 3'b010;
  logic          auto_corr = 1'b0, err_en = 1'b0, fast = 1'b0;
  logic [AW-3:0] win_lo = '0, win_hi = '0;
  logic          req = 1'b0, we = 1'b0, wide = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [127:0]  wdata = '0;
  logic          ready, rvalid, rerr, sec, ded, aerr;
  logic [127:0]  rdata;
  logic [AW-1:0] eaddr;
  logic [7:0]    sbit;

  always #5 clk = ~clk;

  ecc_ram_ctrl #(.LINES(16), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .auto_corr_i(auto_corr),
    .err_resp_en_i(err_en), .fast_nonecc_i(fast), .win_lo_i(win_lo), .win_hi_i(win_hi),
    .req_i(req), .we_i(we), .wide_i(wide), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata), .rerr_o(rerr),
    .sec_o(sec), .ded_o(ded), .addr_err_o(aerr), .err_addr_o(eaddr), .sec_bit_o(sbit)
  );

  int n_chk = 0, n_fail = 0;
  int r_lat;
  logic r_rdy1, r_err, r_sec, r_ded, r_aerr;
  logic [127:0] r_data;
  logic [AW-1:0] r_eaddr;
  logic [7:0] r_bit;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic wd, input logic [2:0] m,
                        input logic [AW-1:0] a, input logic [127:0] d);
    @(negedge clk);
    mode = m; we = w; wide = wd; addr = a; wdata = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    r_lat = 1;
    r_rdy1 = ready;
    while (!rvalid && r_lat < 8) begin
      @(negedge clk);
      r_lat++;
    end
    r_data = rdata; r_err = rerr; r_sec = sec; r_ded = ded;
    r_aerr = aerr; r_eaddr = eaddr; r_bit = sbit;
  endtask

  function automatic logic [127:0] pat(input int l);
    logic [127:0] r;
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = 32'hA000_0000 | 32'(l << 8) | 32'(w);
    return r;
  endfunction

  typedef struct packed {
    logic        w;
    logic [2:0]  m;
    logic [6:0]  a;
    logic [31:0] d;
    logic [1:0]  lat;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 3'b010, 7'd4,  32'h1111_0001, 2'd2, 4'd5},
    '{1'b0, 3'b010, 7'd4,  32'h1111_0001, 2'd2, 4'd5},
    '{1'b0, 3'b010, 7'd5,  32'hA000_0101, 2'd2, 4'd5},
    '{1'b1, 3'b000, 7'd8,  32'h2222_0002, 2'd1, 4'd7},
    '{1'b0, 3'b000, 7'd8,  32'h2222_0002, 2'd2, 4'd7},
    '{1'b1, 3'b001, 7'd9,  32'h3333_0003, 2'd1, 4'd7},
    '{1'b0, 3'b001, 7'd9,  32'h3333_0003, 2'd2, 4'd7},
    '{1'b1, 3'b110, 7'd12, 32'h4444_0004, 2'd1, 4'd8},
    '{1'b0, 3'b101, 7'd12, 32'h4444_0004, 2'd2, 4'd8},
    '{1'b0, 3'b000, 7'd10, 32'hA000_0202, 2'd2, 4'd7}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] bad5;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 ready", 128'(ready), 128'd1);
    check("R12 outputs", {rvalid, sec, ded, aerr}, '0);
    rst_n = 1'b1;

    // R1 line writes
    for (int l = 0; l < 8; l++) begin
      access(1'b1, 1'b1, 3'b010, AW'(l * 4), pat(l));
      if (l == 0) check("R1 write latency", 128'(r_lat), 128'd1);
    end
    access(1'b0, 1'b1, 3'b010, 7'd0, '0);
    check("R1 line readback", r_data, pat(0));
    check("R1 no event", {r_sec, r_ded, r_err}, '0);
    check("R13 ready low in check cycle", 128'(r_rdy1), 128'd0);

    // table walk
    foreach (VECS[i]) begin
      access(VECS[i].w, 1'b0, VECS[i].m, VECS[i].a, 128'(VECS[i].d));
      check($sformatf("R%0d vec%0d latency", VECS[i].rq, i), 128'(r_lat), 128'(VECS[i].lat));
      check($sformatf("R%0d vec%0d data", VECS[i].rq, i), r_data,
            VECS[i].w ? 128'd0 : 128'(VECS[i].d));
      check($sformatf("R%0d vec%0d events", VECS[i].rq, i), {r_sec, r_ded, r_err}, '0);
    end
    access(1'b0, 1'b1, 3'b010, 7'd4, '0);
    check("R5 merged line kept", r_data, {pat(1)[127:32], 32'h1111_0001});
    check("R5 clean after merge", {r_sec, r_ded}, '0);

    // R2 single error in line 4, bit 37
    access(1'b1, 1'b1, 3'b000, 7'd16, pat(4) ^ (128'd1 << 37));
    access(1'b0, 1'b0, 3'b010, 7'd17, '0);
    check("R2 corrected word", r_data, 128'(32'hA000_0401));
    check("R2 sec pulse", {r_sec, r_ded, r_err}, 3'b100);
    check("R2 err addr", 128'(r_eaddr), 128'd17);
    check("R2 bit position", 128'(r_bit), 128'd37);
    access(1'b0, 1'b1, 3'b010, 7'd16, '0);
    check("R4 no write-back, sec again", 128'(r_sec), 128'd1);
    check("R2 corrected line", r_data, pat(4));
    auto_corr = 1'b1;
    access(1'b0, 1'b1, 3'b010, 7'd16, '0);
    check("R4 sec before write-back", 128'(r_sec), 128'd1);
    access(1'b0, 1'b1, 3'b010, 7'd16, '0);
    check("R4 clean after write-back", {r_sec, r_ded}, '0);
    check("R4 data after write-back", r_data, pat(4));
    auto_corr = 1'b0;

    // R3 double error in line 5
    bad5 = pat(5) ^ (128'd1 << 3) ^ (128'd1 << 90);
    access(1'b1, 1'b1, 3'b000, 7'd20, bad5);
    access(1'b0, 1'b1, 3'b010, 7'd20, '0);
    check("R3 ded, no rerr", {r_sec, r_ded, r_err}, 3'b010);
    check("R3 raw data", r_data, bad5);
    err_en = 1'b1;
    access(1'b0, 1'b1, 3'b010, 7'd20, '0);
    check("R3 rerr enabled", {r_ded, r_err}, 2'b11);

    // R6 merge over an uncorrectable line
    access(1'b1, 1'b0, 3'b010, 7'd20, 128'h5555_0005);
    check("R6 rmw latency", 128'(r_lat), 128'd2);
    check("R6 ded and rerr", {r_ded, r_err}, 2'b11);
    access(1'b0, 1'b1, 3'b010, 7'd20, '0);
    check("R6 line clean after merge", {r_sec, r_ded, r_err}, '0);
    check("R6 merged data", r_data, {bad5[127:32], 32'h5555_0005});
    err_en = 1'b0;

    // R7 non-ECC word write keeps old check bits
    access(1'b1, 1'b0, 3'b000, 7'd24, 128'h0000_0000_A000_0601);
    access(1'b0, 1'b0, 3'b010, 7'd24, '0);
    check("R7 check bits untouched (sec)", {r_sec, r_bit}, {1'b1, 8'd0});
    check("R7 ecc read corrects", r_data, 128'(32'hA000_0600));
    access(1'b0, 1'b0, 3'b000, 7'd24, '0);
    check("R7 raw read", r_data, 128'(32'hA000_0601));
    check("R7 no events", {r_sec, r_ded}, '0);

    // R9 fast non-ECC read
    fast = 1'b1;
    access(1'b0, 1'b0, 3'b001, 7'd24, '0);
    check("R9 fast latency", 128'(r_lat), 128'd1);
    check("R9 fast data", r_data, 128'(32'hA000_0601));
    access(1'b0, 1'b0, 3'b010, 7'd24, '0);
    check("R9 ecc not shortened", 128'(r_lat), 128'd2);
    access(1'b0, 1'b1, 3'b111, 7'd24, '0);
    check("R8 reserved uses fast path", 128'(r_lat), 128'd1);
    fast = 1'b0;

    // R8 reserved code acts as non-ECC
    access(1'b0, 1'b0, 3'b100, 7'd24, '0);
    check("R8 reserved raw", {r_sec, r_data[31:0]}, {1'b0, 32'hA000_0601});

    // R10 window
    win_lo = 5'd6; win_hi = 5'd6;
    access(1'b0, 1'b0, 3'b011, 7'd24, '0);
    check("R10 inside window", {r_sec, r_data[31:0]}, {1'b1, 32'hA000_0600});
    win_lo = 5'd7; win_hi = 5'd8;
    access(1'b0, 1'b0, 3'b011, 7'd24, '0);
    check("R10 outside window", {r_sec, r_data[31:0]}, {1'b0, 32'hA000_0601});

    // R11 address errors
    err_en = 1'b1;
    access(1'b0, 1'b0, 3'b010, 7'd64, '0);
    check("R11 range latency", 128'(r_lat), 128'd1);
    check("R11 range flags", {r_aerr, r_err, r_sec, r_ded}, 4'b1100);
    check("R11 err addr", 128'(r_eaddr), 128'd64);
    check("R11 zero data", r_data, '0);
    err_en = 1'b0;
    access(1'b0, 1'b1, 3'b010, 7'd1, '0);
    check("R11 misaligned line", {r_aerr, r_err}, 2'b10);
    access(1'b1, 1'b1, 3'b010, 7'd65, 128'hDEAD);
    access(1'b0, 1'b1, 3'b010, 7'd0, '0);
    check("R11 no ram access", r_data, pat(0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule